// File: doc/BRIEF.md
# Single-wire bus master controller

This block is the master side of a single-wire open-drain bus. It turns host commands into the bus waveforms, timed from a half-microsecond timebase that it derives from the system clock. It drives a pulldown enable, and an external open-drain pad turns that into the line. It reads the line back through a plain input.

The host can start four kinds of operation. A bus reset is a long low pulse, followed by a presence check and a recovery wait. A single bit slot carries one bit. A byte is eight slots, least significant bit first. A read uses the same slot as a write of one: the master releases the line early, so a slave that holds the line low is seen as a zero.

Each slot samples the line late in the permitted read window. Every slot lasts its full slot time, so the slave always gets its recovery time before the next falling edge. A mode input selects standard or fast timing. The block samples this input once, when it accepts a command.

Top module: `sline_master`

## Requirements
- R1: A reset command (cmd_op = 0) asserts bus_pull for exactly 480 µs in standard mode or 70 µs in fast mode (overdrive = 1), and then releases it.
- R2: During a reset the line is sampled 70 µs (standard) or 8.5 µs (fast) after release. presence is set to 1 if the line was low there and to 0 otherwise, and it changes only when done is asserted.
- R3: A reset signals done no earlier than 480 µs (standard) or 48 µs (fast) after the line is released, and no later than two clocks beyond that.
- R4: A slot that writes a one, which is also the read slot, asserts bus_pull for 6 µs (standard) or 1 µs (fast). A bit command (cmd_op = 1, bit value in cmd_data[0]) returns the line level sampled 13 µs (standard) or 2 µs (fast) after the slot's falling edge in rd_data[0], with the other bits of rd_data at zero.
- R5: A slot that writes a zero asserts bus_pull for 60 µs (standard) or 7.5 µs (fast).
- R6: Consecutive slot starts within one operation are at least one full slot time apart (70 µs standard, 10 µs fast) and at most two clocks more.
- R7: A byte command (cmd_op = 2) sends cmd_data[0] first and cmd_data[7] last. It returns the sampled bits with the first sample in rd_data[0], so writing 0xFF reads the slave's byte.
- R8: While busy is 1, commands are ignored, and a change of overdrive does not alter the timing of the running operation. The code cmd_op = 3 is reserved and is ignored even when the block is idle.
- R9: done is a single-cycle pulse in the first cycle in which busy is 0 again. rd_data changes only together with done after a bit or byte command, and it keeps its value across a reset command.
- R10: After the synchronous reset, bus_pull, busy, done and presence are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is 0 |
| cmd_op | input | 2 | 0 reset, 1 bit slot, 2 byte, 3 reserved |
| cmd_data | input | 8 | Bits to write, LSB first; bit 0 for a bit command |
| overdrive | input | 1 | 1 selects fast timing, sampled at acceptance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last reset's presence check |
| rd_data | output | 8 | Sampled bits of the last bit or byte command |
| bus_pull | output | 1 | Pulldown enable for the open-drain line |
| bus_in | input | 1 | Line level read back |

## Verification
The hardest case to reach from the ports is a command, together with a change of mode, that arrives while a multi-slot byte is still running. The bench can only show that it had no effect after the fact, by the widths and spacing of the remaining pulses and by the absence of any extra pulse. The stimulus raises cmd_valid with a reset code and flips overdrive partway through a fast byte. It then measures every low pulse and every slot spacing, and watches the idle line afterwards. A bench slave model answers each slot from a chosen byte and each reset with a presence window that straddles the fixed sample time. This lets both presence outcomes and both read values be reached on demand.

// File: rtl/sline_pkg.sv
// Shared types for the single-wire master.
// Assumes all durations are counted in half-microsecond units.
package sline_pkg;
    parameter int TW = 11;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_BIT   = 2'd1,
        OP_BYTE  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef struct packed {
        logic [TW-1:0] w1;
        logic [TW-1:0] w0;
        logic [TW-1:0] smp;
        logic [TW-1:0] slot;
        logic [TW-1:0] rstl;
        logic [TW-1:0] psmp;
        logic [TW-1:0] rsth;
    } tset_t;
endpackage

// File: rtl/sline_timebase.sv
// Half-microsecond tick generator.
// Assumes HALF_US_CLKS clocks make 0.5 us. The count is held at zero while
// clr is high, so the first tick of an operation always falls a full period
// after it starts.
module sline_timebase #(
    parameter int HALF_US_CLKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (HALF_US_CLKS <= 1) begin : g_direct
            // Every clock is a tick when one clock lasts half a microsecond.
            assign tick = !clr;
        end else begin : g_count
            localparam int PW = $clog2(HALF_US_CLKS);
            localparam logic [PW-1:0] LAST = PW'(HALF_US_CLKS - 1);
            logic [PW-1:0] pre;

            // Prescale counter that wraps each half microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    pre <= '0;
                end else if (pre == LAST) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end

            assign tick = (pre == LAST) && !clr;
        end
    endgenerate
endmodule

// File: rtl/sline_timing.sv
// Timing set selection for standard and fast mode.
// Assumes every value is in half-microsecond units and fits in TW bits.
module sline_timing
    import sline_pkg::*;
#(
    parameter int STD_W1   = 12,
    parameter int STD_W0   = 120,
    parameter int STD_SMP  = 26,
    parameter int STD_SLOT = 140,
    parameter int STD_RSTL = 960,
    parameter int STD_PSMP = 140,
    parameter int STD_RSTH = 960,
    parameter int OD_W1    = 2,
    parameter int OD_W0    = 15,
    parameter int OD_SMP   = 4,
    parameter int OD_SLOT  = 20,
    parameter int OD_RSTL  = 140,
    parameter int OD_PSMP  = 17,
    parameter int OD_RSTH  = 96
) (
    input  logic  fast,
    output tset_t tm
);
    localparam tset_t STD_SET = '{w1: TW'(STD_W1), w0: TW'(STD_W0),
                                  smp: TW'(STD_SMP), slot: TW'(STD_SLOT),
                                  rstl: TW'(STD_RSTL), psmp: TW'(STD_PSMP),
                                  rsth: TW'(STD_RSTH)};
    localparam tset_t OD_SET  = '{w1: TW'(OD_W1), w0: TW'(OD_W0),
                                  smp: TW'(OD_SMP), slot: TW'(OD_SLOT),
                                  rstl: TW'(OD_RSTL), psmp: TW'(OD_PSMP),
                                  rsth: TW'(OD_RSTH)};

    // Pick the active timing set.
    always_comb begin
        tm = fast ? OD_SET : STD_SET;
    end
endmodule

// File: rtl/sline_engine.sv
// Phase engine: runs a single reset sequence or a single bit slot.
// Assumes tm is held stable for the whole phase and that a start request
// arrives only while the engine is idle. phase_done pulses at the end.
module sline_engine
    import sline_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_rst,
    input  logic  start_slot,
    input  logic  wbit,
    input  logic  tick,
    input  logic  line_in,
    input  tset_t tm,
    output logic  pull,
    output logic  active,
    output logic  phase_done,
    output logic  sample,
    output logic  pres
);
    typedef enum logic [1:0] {E_IDLE, E_RLOW, E_RREL, E_SLOT} est_e;

    est_e          state;
    logic [TW-1:0] t;
    logic          wb;

    // Phase sequencing, elapsed-time count and line sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= E_IDLE;
            t          <= '0;
            wb         <= 1'b0;
            phase_done <= 1'b0;
            sample     <= 1'b0;
            pres       <= 1'b0;
        end else begin
            phase_done <= 1'b0;
            case (state)
                E_IDLE: begin
                    t <= '0;
                    if (start_rst) begin
                        state <= E_RLOW;
                    end else if (start_slot) begin
                        state <= E_SLOT;
                        wb    <= wbit;
                    end
                end
                E_RLOW: begin
                    if (tick) begin
                        if (t == tm.rstl - 1'b1) begin
                            state <= E_RREL;
                            t     <= '0;
                        end else begin
                            t <= t + 1'b1;
                        end
                    end
                end
                E_RREL: begin
                    if (tick) begin
                        if (t == tm.psmp - 1'b1) begin
                            pres <= !line_in;
                        end
                        if (t == tm.rsth - 1'b1) begin
                            state      <= E_IDLE;
                            phase_done <= 1'b1;
                        end else begin
                            t <= t + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (t == tm.smp - 1'b1) begin
                            sample <= line_in;
                        end
                        if (t == tm.slot - 1'b1) begin
                            state      <= E_IDLE;
                            phase_done <= 1'b1;
                        end else begin
                            t <= t + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Pulldown decode from phase and elapsed time.
    always_comb begin
        pull   = (state == E_RLOW) ||
                 ((state == E_SLOT) && (t < (wb ? tm.w1 : tm.w0)));
        active = (state != E_IDLE);
    end
endmodule

// File: rtl/sline_master.sv
// Single-wire bus master top. It accepts a command while idle, latches the
// mode, and chains engine phases: one phase for a reset or a bit, and
// DATA_W slots for a byte.
// Assumes bus_in is already synchronised to clk.
module sline_master
    import sline_pkg::*;
#(
    parameter int HALF_US_CLKS = 25,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              overdrive,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_pull,
    input  logic              bus_in
);
    localparam int CW = $clog2(DATA_W + 1);

    op_e               op_q;
    logic              od_q;
    logic              run;
    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     cnt;
    logic              accept, cont;
    logic              start_rst, start_slot, wbit;
    logic              tick, eng_active, eng_done, eng_sample, eng_pres;
    tset_t             tm;

    // Command acceptance and slot chaining requests.
    always_comb begin
        accept     = cmd_valid && !run && (op_e'(cmd_op) != OP_NONE);
        cont       = run && eng_done && (op_q != OP_RESET) && (cnt != CW'(1));
        start_rst  = accept && (op_e'(cmd_op) == OP_RESET);
        start_slot = (accept && (op_e'(cmd_op) != OP_RESET)) || cont;
        wbit       = accept ? cmd_data[0] : shreg[1];
    end

    // Operation state, shift register and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_RESET;
            od_q     <= 1'b0;
            run      <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            done     <= 1'b0;
            presence <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                run   <= 1'b1;
                op_q  <= op_e'(cmd_op);
                od_q  <= overdrive;
                shreg <= cmd_data;
                cnt   <= (op_e'(cmd_op) == OP_BYTE) ? CW'(DATA_W) : CW'(1);
            end else if (run && eng_done) begin
                if (op_q == OP_RESET) begin
                    presence <= eng_pres;
                    run      <= 1'b0;
                    done     <= 1'b1;
                end else begin
                    shreg <= {eng_sample, shreg[DATA_W-1:1]};
                    cnt   <= cnt - 1'b1;
                    if (cnt == CW'(1)) begin
                        run  <= 1'b0;
                        done <= 1'b1;
                        if (op_q == OP_BYTE) begin
                            rd_data <= {eng_sample, shreg[DATA_W-1:1]};
                        end else begin
                            rd_data <= {{(DATA_W-1){1'b0}}, eng_sample};
                        end
                    end
                end
            end
        end
    end

    assign busy = run;

    sline_timebase #(.HALF_US_CLKS(HALF_US_CLKS)) tb_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!eng_active),
        .tick (tick)
    );

    sline_timing tim_i (
        .fast(od_q),
        .tm  (tm)
    );

    sline_engine eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rst (start_rst),
        .start_slot(start_slot),
        .wbit      (wbit),
        .tick      (tick),
        .line_in   (bus_in),
        .tm        (tm),
        .pull      (bus_pull),
        .active    (eng_active),
        .phase_done(eng_done),
        .sample    (eng_sample),
        .pres      (eng_pres)
    );
endmodule

// File: rtl/sline_master_chk.sv
// Protocol checker for the single-wire master, bound to the top module.
// Assumes it sees the top-level ports only.
module sline_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic              presence,
    input logic [DATA_W-1:0] rd_data,
    input logic              bus_pull
);
    // R8: an idle block never pulls the line.
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_pull);

    // R8: a valid command taken while idle makes the block busy.
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op != 2'd3) |=> busy);

    // R8: the reserved code leaves the block idle.
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd3) |=> !busy);

    // R9: done lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done appears together with busy low.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: every end of busy is marked by done.
    a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: read data only moves with done.
    a_r9_rd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

    // R2: the presence result only moves with done.
    a_r2_pres_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(presence));
endmodule

bind sline_master sline_master_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .busy     (busy),
    .done     (done),
    .presence (presence),
    .rd_data  (rd_data),
    .bus_pull (bus_pull)
);

// File: tb/sline_master_tb_top.sv
// Self-checking bench for sline_master, with a slave model on the line.
module sline_master_tb_top;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       overdrive = 1'b0;
    logic       busy, done, presence, bus_pull, bus_in;
    logic [7:0] rd_data;
    logic       slave_low = 1'b0;

    always #10 clk = ~clk;

    assign bus_in = !(bus_pull || slave_low);

    sline_master #(.HALF_US_CLKS(H), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .overdrive(overdrive), .busy(busy), .done(done),
        .presence(presence), .rd_data(rd_data), .bus_pull(bus_pull),
        .bus_in(bus_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic int tw1(bit od);   return od ? 2 : 12;    endfunction
    function automatic int tw0(bit od);   return od ? 15 : 120;  endfunction
    function automatic int tsmp(bit od);  return od ? 4 : 26;    endfunction
    function automatic int tslot(bit od); return od ? 20 : 140;  endfunction
    function automatic int trstl(bit od); return od ? 140 : 960; endfunction
    function automatic int trsth(bit od); return od ? 96 : 960;  endfunction

    function automatic logic [7:0] exp_read(int nbits, logic [7:0] w, logic [7:0] s);
        return (nbits == 1) ? {7'd0, w[0] & s[0]} : (w & s);
    endfunction

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle counter, advanced on the active edge.
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Line monitor and slave model, evaluated away from the active edge.
    bit     prev_pull = 1'b0;
    int     width = 0;
    int     nw = 0;
    int     widths[0:15];
    longint rises[0:15];
    longint release_cyc = 0;
    bit     cur_od = 1'b0;
    bit     slave_present = 1'b0;
    logic [7:0] slave_byte = 8'hFF;
    int     sidx = 0;
    int     hold = 0;
    int     pres_wait = 0;
    int     pres_hold = 0;

    always @(negedge clk) begin
        if (bus_pull && !prev_pull) begin
            if (nw < 16) rises[nw] = cyc;
            width = 0;
            if (sidx < 8 && !slave_byte[sidx]) hold = tsmp(cur_od) * H + 4;
            sidx++;
        end
        if (bus_pull) width++;
        if (!bus_pull && prev_pull) begin
            if (nw < 16) widths[nw] = width;
            nw++;
            if (width > 100) begin
                release_cyc = cyc;
                if (slave_present) pres_wait = cur_od ? 8 : 60;
            end
        end
        if (pres_wait > 0) begin
            pres_wait--;
            if (pres_wait == 0) pres_hold = cur_od ? 60 : 600;
        end
        slave_low = (hold > 0) || (pres_hold > 0);
        if (hold > 0) hold--;
        if (pres_hold > 0) pres_hold--;
        prev_pull = bus_pull;
    end

    task automatic issue(input logic [1:0] op, input logic [7:0] d, input bit od);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        overdrive = od;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Wait for done; optionally disturb the inputs at iteration inj.
    task automatic wait_done(input int inj, input bit od, output longint dcyc);
        bit seen = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            if (i == inj) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'd0;
                overdrive = !od;
            end else if (i == inj + 1) begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        dcyc = cyc;
        chk("R9 done seen", seen, seen, 1);
    endtask

    task automatic run_reset(input bit od, input bit present);
        logic [7:0] rd_before = rd_data;
        longint dcyc;
        cur_od = od; slave_present = present; slave_byte = 8'hFF; sidx = 0;
        @(negedge clk); nw = 0;
        issue(2'd0, 8'h00, od);
        wait_done(-10, od, dcyc);
        chk("R1 reset low width", nw == 1 && widths[0] == trstl(od) * H, widths[0], trstl(od) * H);
        chk("R2 presence result", presence == present, presence, present);
        chk("R3 release to done", (dcyc - release_cyc) >= trsth(od) * H &&
            (dcyc - release_cyc) <= trsth(od) * H + 2, dcyc - release_cyc, trsth(od) * H);
        chk("R9 rd_data kept over reset", rd_data == rd_before, rd_data, rd_before);
        slave_present = 1'b0;
    endtask

    task automatic run_slots(input bit od, input int nbits, input logic [7:0] w,
                             input logic [7:0] s, input int inj);
        logic [7:0] expv = exp_read(nbits, w, s);
        bit         pres_before = presence;
        longint     dcyc;
        cur_od = od; slave_byte = s; sidx = 0;
        @(negedge clk); nw = 0;
        issue((nbits == 1) ? 2'd1 : 2'd2, w, od);
        wait_done(inj, od, dcyc);
        chk(nbits == 1 ? "R4 bit read value" : "R7 byte read value", rd_data == expv, rd_data, expv);
        chk("R2 presence unchanged by slots", presence == pres_before, presence, pres_before);
        for (int i = 0; i < nbits; i++) begin
            int e = (w[i] ? tw1(od) : tw0(od)) * H;
            if (w[i]) chk("R4 write-one low width", widths[i] == e, widths[i], e);
            else      chk("R5 write-zero low width", widths[i] == e, widths[i], e);
        end
        for (int i = 1; i < nbits; i++) begin
            longint g = rises[i] - rises[i-1];
            chk("R6 slot spacing", g >= tslot(od) * H && g <= tslot(od) * H + 2, g, tslot(od) * H);
        end
        if (inj >= 0) begin
            repeat (20) @(negedge clk);
            chk("R8 command during busy ignored", nw == nbits && !busy, nw, nbits);
        end
        slave_byte = 8'hFF;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 bus_pull after reset", bus_pull == 0, bus_pull, 0);
        chk("R10 busy after reset", busy == 0, busy, 0);
        chk("R10 done after reset", done == 0, done, 0);
        chk("R10 presence after reset", presence == 0, presence, 0);
        chk("R10 rd_data after reset", rd_data == 0, rd_data, 0);

        // R8 reserved code is ignored
        nw = 0;
        issue(2'd3, 8'h00, 1'b0);
        begin
            bit any = 1'b0;
            for (int i = 0; i < 10; i++) begin
                if (busy || done) any = 1'b1;
                @(negedge clk);
            end
            chk("R8 reserved op ignored", !any && nw == 0, any, 0);
        end

        run_reset(1'b0, 1'b1);
        run_reset(1'b0, 1'b0);
        run_reset(1'b1, 1'b1);
        run_reset(1'b1, 1'b0);

        run_slots(1'b0, 1, 8'h01, 8'hFF, -10);
        run_slots(1'b0, 1, 8'h01, 8'hFE, -10);
        run_slots(1'b0, 1, 8'h00, 8'hFF, -10);
        run_slots(1'b1, 1, 8'h01, 8'hFF, -10);
        run_slots(1'b1, 1, 8'h01, 8'h00, -10);
        run_slots(1'b1, 1, 8'h00, 8'hFF, -10);
        run_reset(1'b0, 1'b1);

        run_slots(1'b0, 8, 8'hFF, 8'h3C, -10);
        run_slots(1'b0, 8, 8'hA5, 8'hFF, -10);
        run_slots(1'b1, 8, 8'hFF, 8'h81, 45);
        run_slots(1'b0, 8, 8'h5A, 8'hF0, 300);

        for (int k = 0; k < 12; k++) begin
            int         op = $urandom % 3;
            bit         od = 1'($urandom);
            logic [7:0] w  = 8'($urandom);
            logic [7:0] s  = 8'($urandom);
            if ($urandom % 2 == 0) w = 8'hFF;
            if (op == 0)      run_reset(od, 1'($urandom));
            else if (op == 1) run_slots(od, 1, w, s, -10);
            else              run_slots(od, 8, w, s, -10);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule